// File: doc/BRIEF.md
# DMA Protected High-Memory Region Guard

This block guards one protected window of host physical memory against device DMA. Software programs a bottom register and a top register through a 64-bit configuration port that selects a register by byte offset. Each register holds a 2 MiB granule number: its low bits are hardwired. Software reads those low bits back as zero. The comparator treats them as zero for the bottom bound and as all ones for the top bound. A separate protection-enable control drives the `prot_en` input. While that input is high, the region is armed and the register contents are frozen.

Every cycle, a DMA request may present an address together with a valid strobe. One clock later the block returns a valid flag and a blocked flag. The blocked flag is high when the address lies inside the armed window. A top bound programmed below the bottom bound turns the window off. If the two bounds are equal, the window is a single granule. Software can find the granule size by writing all ones to a register and checking which low bits read back as zero. A build-time parameter can remove the region altogether. In that build both registers read as zero and nothing is ever blocked.

Top module: `dma_region_guard`

## Requirements
- R1: After reset, both registers read back as zero, and `blk_valid` and `blk_hit` are low.
- R2: The bottom register sits at offset 0x0 and the top register at offset 0x8 on `cfg_off`. In each register, bits 63:21 are writable and bits 20:0 always read zero, so writing all ones reads back 0xFFFF_FFFF_FFE0_0000.
- R3: A write to any other offset changes neither register, and a read of any other offset returns zero.
- R4: An armed request is blocked when its address lies between the bottom value with bits 20:0 cleared and the top value with bits 20:0 set, both ends included. Addresses just outside either end are not blocked.
- R5: When the top value is below the bottom value in bits HAW-1:21, no address is blocked.
- R6: When the top and bottom values are equal in bits HAW-1:21, exactly that one 2 MiB granule is blocked.
- R7: Address bits at and above HAW (39 by default) play no part in the comparison. This holds both for request addresses and for register contents.
- R8: While `prot_en` is low, no request is blocked.
- R9: While `prot_en` is high, writes to either register are ignored.
- R10: `blk_valid` is `req_valid` delayed by one clock. `blk_hit` is the result for that request, and it is low whenever `blk_valid` is low.
- R11: When the region is built as absent, writes have no effect, both registers read zero and no request is ever blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_en | input | 1 | Arms the check and locks the registers |
| cfg_wr | input | 1 | Register write strobe |
| cfg_off | input | 4 | Register byte offset |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Read data for the selected offset (combinational) |
| req_valid | input | 1 | DMA request address is valid |
| req_addr | input | 64 | DMA request address |
| blk_valid | output | 1 | Result valid, one cycle after the request |
| blk_hit | output | 1 | Request falls in the armed protected window |

## Verification
The assertions assume that `prot_en` is sampled in the same cycle as the request it governs. They also assume that reset is held for at least one clock, so that a `$past` of the enable and of the bounds is always defined. The bench changes `prot_en`, the register writes and the request signals only on falling edges, so each input is stable at the capturing edge. Every register is programmed with the enable low and then read back before the window is armed. Requests are issued one at a time, and each result is sampled on the falling edge after the capturing clock.

// File: rtl/dmaprot_pkg.sv
package dmaprot_pkg;
   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_BASE  = 2'd1,
      SEL_LIMIT = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/dmaprot_decode.sv
module dmaprot_decode
   import dmaprot_pkg::*;
#(
   parameter int          OFF_W     = 4,
   parameter logic [3:0]  BASE_OFF  = 4'h0,
   parameter logic [3:0]  LIMIT_OFF = 4'h8
) (
   input  logic             cfg_wr,
   input  logic [OFF_W-1:0] cfg_off,
   input  logic             lock,
   output reg_sel_e         sel,
   output logic             wr_base,
   output logic             wr_limit
);
   always_comb begin
      if (cfg_off == OFF_W'(BASE_OFF))       sel = SEL_BASE;
      else if (cfg_off == OFF_W'(LIMIT_OFF)) sel = SEL_LIMIT;
      else                                   sel = SEL_NONE;
   end

   assign wr_base  = cfg_wr && !lock && (sel == SEL_BASE);
   assign wr_limit = cfg_wr && !lock && (sel == SEL_LIMIT);
endmodule

// File: rtl/dmaprot_bound_reg.sv
module dmaprot_bound_reg #(
   parameter int REG_W    = 64,
   parameter int GRAN_LSB = 21,
   parameter bit PRESENT  = 1'b1,
   localparam int FW      = REG_W - GRAN_LSB
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             lock,
   input  logic [REG_W-1:0] wdata,
   output logic [FW-1:0]    field_o,
   output logic [REG_W-1:0] rdata_o
);
   generate
      if (PRESENT) begin : g_rw
         logic [FW-1:0] field_q;
         always_ff @(posedge clk) begin
            if (!rst_n)     field_q <= '0;
            else if (wr_en) field_q <= wdata[REG_W-1:GRAN_LSB];
         end
         assign field_o = field_q;

         logic unused_low_wdata;
         assign unused_low_wdata = ^wdata[GRAN_LSB-1:0];

         AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            lock |=> $stable(field_q)); // R9
      end else begin : g_ro
         assign field_o = '0;
         logic unused_ro_inputs;
         assign unused_ro_inputs = ^{clk, rst_n, wr_en, lock, wdata};
      end
   endgenerate

   assign rdata_o = {field_o, {GRAN_LSB{1'b0}}};
endmodule

// File: rtl/dmaprot_compare.sv
module dmaprot_compare #(
   parameter int HAW      = 39,
   parameter int GRAN_LSB = 21,
   localparam int CW      = HAW - GRAN_LSB
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           prot_en,
   input  logic           req_valid,
   input  logic [HAW-1:0] req_addr,
   input  logic [CW-1:0]  base_c,
   input  logic [CW-1:0]  lim_c,
   output logic           blk_valid,
   output logic           blk_hit
);
   logic [CW-1:0] addr_c;
   logic          win_open;
   logic          in_win;
   logic          hit_d;

   assign addr_c   = req_addr[HAW-1:GRAN_LSB];
   assign win_open = (lim_c >= base_c);
   assign in_win   = (addr_c >= base_c) && (addr_c <= lim_c);
   assign hit_d    = req_valid && prot_en && win_open && in_win;

   logic unused_addr_low;
   assign unused_addr_low = ^req_addr[GRAN_LSB-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_valid <= 1'b0;
         blk_hit   <= 1'b0;
      end else begin
         blk_valid <= req_valid;
         blk_hit   <= hit_d;
      end
   end

   AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      blk_hit |-> $past(prot_en)); // R8
   AST_HIT_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      blk_hit |-> blk_valid); // R10
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> blk_valid); // R10
   AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      blk_hit |-> $past(lim_c >= base_c)); // R5
endmodule

// File: rtl/dma_region_guard.sv
module dma_region_guard
   import dmaprot_pkg::*;
#(
   parameter int         REG_W      = 64,
   parameter int         HAW        = 39,
   parameter int         GRAN_LSB   = 21,
   parameter bit         HAS_REGION = 1'b1,
   parameter int         OFF_W      = 4,
   parameter logic [3:0] BASE_OFF   = 4'h0,
   parameter logic [3:0] LIMIT_OFF  = 4'h8,
   localparam int        FW         = REG_W - GRAN_LSB,
   localparam int        CW         = HAW - GRAN_LSB
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             prot_en,
   input  logic             cfg_wr,
   input  logic [OFF_W-1:0] cfg_off,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   input  logic             req_valid,
   input  logic [REG_W-1:0] req_addr,
   output logic             blk_valid,
   output logic             blk_hit
);
   generate
      if (HAW > REG_W || HAW < 2)
         $error("dma_region_guard: HAW must lie in 2..REG_W");
      if (GRAN_LSB < 1 || GRAN_LSB >= HAW)
         $error("dma_region_guard: GRAN_LSB must lie in 1..HAW-1");
      if (BASE_OFF == LIMIT_OFF)
         $error("dma_region_guard: register offsets must differ");
      if (OFF_W < 1 || OFF_W > 4)
         $error("dma_region_guard: OFF_W must lie in 1..4");
   endgenerate

   reg_sel_e         sel;
   logic             wr_base, wr_limit;
   logic [FW-1:0]    base_f, lim_f;
   logic [REG_W-1:0] base_rd, lim_rd;

   dmaprot_decode #(
      .OFF_W(OFF_W), .BASE_OFF(BASE_OFF), .LIMIT_OFF(LIMIT_OFF)
   ) u_decode (
      .cfg_wr(cfg_wr), .cfg_off(cfg_off), .lock(prot_en),
      .sel(sel), .wr_base(wr_base), .wr_limit(wr_limit)
   );

   dmaprot_bound_reg #(
      .REG_W(REG_W), .GRAN_LSB(GRAN_LSB), .PRESENT(HAS_REGION)
   ) u_base (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_base), .lock(prot_en),
      .wdata(cfg_wdata), .field_o(base_f), .rdata_o(base_rd)
   );

   dmaprot_bound_reg #(
      .REG_W(REG_W), .GRAN_LSB(GRAN_LSB), .PRESENT(HAS_REGION)
   ) u_limit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_limit), .lock(prot_en),
      .wdata(cfg_wdata), .field_o(lim_f), .rdata_o(lim_rd)
   );

   always_comb begin
      unique case (sel)
         SEL_BASE:  cfg_rdata = base_rd;
         SEL_LIMIT: cfg_rdata = lim_rd;
         default:   cfg_rdata = '0;
      endcase
   end

   generate
      if (HAW < REG_W) begin : g_hi_unused
         logic unused_hi;
         assign unused_hi = ^{req_addr[REG_W-1:HAW], base_f[FW-1:CW], lim_f[FW-1:CW]};
      end
   endgenerate

   logic arm;
   assign arm = prot_en && HAS_REGION;

   dmaprot_compare #(
      .HAW(HAW), .GRAN_LSB(GRAN_LSB)
   ) u_cmp (
      .clk(clk), .rst_n(rst_n), .prot_en(arm), .req_valid(req_valid),
      .req_addr(req_addr[HAW-1:0]), .base_c(base_f[CW-1:0]), .lim_c(lim_f[CW-1:0]),
      .blk_valid(blk_valid), .blk_hit(blk_hit)
   );

   AST_RO_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[GRAN_LSB-1:0] == '0); // R2
   AST_NOCAP_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !HAS_REGION |-> !blk_hit); // R11
endmodule

// File: tb/tb_dma_region_guard.sv
module tb_dma_region_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prot_en = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [3:0]  cfg_off = 4'h0;
   logic [63:0] cfg_wdata = '0;
   logic [63:0] cfg_rdata, nc_rdata;
   logic        req_valid = 1'b0;
   logic [63:0] req_addr = '0;
   logic        blk_valid, blk_hit, nc_valid, nc_hit;

   int compared = 0;
   int mismatched = 0;

   always #2.5 clk = ~clk;

   dma_region_guard dut (
      .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .cfg_wr(cfg_wr),
      .cfg_off(cfg_off), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .req_valid(req_valid), .req_addr(req_addr),
      .blk_valid(blk_valid), .blk_hit(blk_hit)
   );

   dma_region_guard #(.HAS_REGION(1'b0)) dut_nc (
      .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .cfg_wr(cfg_wr),
      .cfg_off(cfg_off), .cfg_wdata(cfg_wdata), .cfg_rdata(nc_rdata),
      .req_valid(req_valid), .req_addr(req_addr),
      .blk_valid(nc_valid), .blk_hit(nc_hit)
   );

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] off, logic [63:0] d);
      @(negedge clk);
      cfg_off = off; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd(logic [3:0] off, output logic [63:0] d);
      @(negedge clk);
      cfg_off = off;
      #1 d = cfg_rdata;
   endtask

   task automatic probe(string req, logic [63:0] a, logic exp_hit);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      chk({req, " valid"}, 64'(blk_valid), 64'd1);
      chk({req, " hit"}, 64'(blk_hit), 64'(exp_hit));
   endtask

   task automatic set_window(logic [63:0] b, logic [63:0] l);
      @(negedge clk) prot_en = 1'b0;
      wr(4'h0, b);
      wr(4'h8, l);
      @(negedge clk) prot_en = 1'b1;
   endtask

   task automatic t_reset();
      logic [63:0] d;
      chk("R1 blk_valid", 64'(blk_valid), 64'd0);
      chk("R1 blk_hit", 64'(blk_hit), 64'd0);
      rd(4'h0, d); chk("R1 base", d, 64'd0);
      rd(4'h8, d); chk("R1 limit", d, 64'd0);
   endtask

   task automatic t_probe_granule();
      logic [63:0] d;
      wr(4'h0, '1); rd(4'h0, d); chk("R2 base ones", d, 64'hFFFF_FFFF_FFE0_0000);
      wr(4'h8, '1); rd(4'h8, d); chk("R2 limit ones", d, 64'hFFFF_FFFF_FFE0_0000);
      wr(4'h4, 64'h1234_5678_9ABC_DEF0);
      rd(4'h4, d); chk("R3 unmapped read", d, 64'd0);
      rd(4'h0, d); chk("R3 base untouched", d, 64'hFFFF_FFFF_FFE0_0000);
      rd(4'h8, d); chk("R3 limit untouched", d, 64'hFFFF_FFFF_FFE0_0000);
   endtask

   task automatic t_window();
      logic [63:0] d;
      set_window(64'h0000_0010_0020_0000, 64'hF000_0010_005F_FFFF);
      rd(4'h8, d); chk("R7 limit readback", d, 64'hF000_0010_0040_0000);
      probe("R4 below base", 64'h0000_0010_001F_FFFF, 1'b0);
      probe("R4 at base", 64'h0000_0010_0020_0000, 1'b1);
      probe("R4 last byte", 64'h0000_0010_005F_FFFF, 1'b1);
      probe("R4 past limit", 64'h0000_0010_0060_0000, 1'b0);
      probe("R7 high alias", 64'hFF00_0010_0030_0000, 1'b1);
      probe("R7 above HAW only", 64'h0000_0090_0030_0000, 1'b1);
   endtask

   task automatic t_single();
      set_window(64'h0000_0020_0000_0000, 64'h0000_0020_0000_0000);
      probe("R6 granule start", 64'h0000_0020_0000_0000, 1'b1);
      probe("R6 granule end", 64'h0000_0020_001F_FFFF, 1'b1);
      probe("R6 next granule", 64'h0000_0020_0020_0000, 1'b0);
      probe("R6 prev granule", 64'h0000_001F_FFFF_FFFF, 1'b0);
   endtask

   task automatic t_inverted();
      set_window(64'h0000_0030_0040_0000, 64'h0000_0030_0000_0000);
      probe("R5 at limit", 64'h0000_0030_0000_0000, 1'b0);
      probe("R5 at base", 64'h0000_0030_0040_0000, 1'b0);
   endtask

   task automatic t_enable_lock();
      logic [63:0] d;
      set_window(64'h0000_0040_0000_0000, 64'h0000_0040_0020_0000);
      wr(4'h0, 64'h0000_0001_0000_0000);
      wr(4'h8, 64'h0000_0002_0000_0000);
      rd(4'h0, d); chk("R9 base locked", d, 64'h0000_0040_0000_0000);
      rd(4'h8, d); chk("R9 limit locked", d, 64'h0000_0040_0020_0000);
      probe("R9 still guarded", 64'h0000_0040_0010_0000, 1'b1);
      @(negedge clk) prot_en = 1'b0;
      probe("R8 disarmed", 64'h0000_0040_0010_0000, 1'b0);
      @(negedge clk) prot_en = 1'b1;
      @(negedge clk);
      chk("R10 idle valid", 64'(blk_valid), 64'd0);
      chk("R10 idle hit", 64'(blk_hit), 64'd0);
   endtask

   task automatic t_nocap();
      logic [63:0] d;
      @(negedge clk) prot_en = 1'b0;
      wr(4'h0, '1);
      cfg_off = 4'h0; #1 d = nc_rdata; chk("R11 base ro", d, 64'd0);
      wr(4'h8, '1);
      cfg_off = 4'h8; #1 d = nc_rdata; chk("R11 limit ro", d, 64'd0);
      @(negedge clk) prot_en = 1'b1;
      @(negedge clk);
      req_valid = 1'b1; req_addr = 64'h0000_0010_0000_0000;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R11 valid", 64'(nc_valid), 64'd1);
      chk("R11 never hit", 64'(nc_hit), 64'd0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_probe_granule();
            t_window();
            t_single();
            t_inverted();
            t_enable_lock();
            t_nocap();
         end
         begin
            repeat (20000) @(posedge clk);
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule